// File: doc/BRIEF.md
# SMBus Target Register Responder

This block is the protocol layer of an SMBus target device. It sits above a byte-level I2C slave engine: the engine reports start (first or repeated) and stop as single-cycle pulses, hands over every received byte on an input stream, asks for bytes to transmit on an output stream, and reports a host NACK after a transmitted byte. The responder matches its own 7-bit address, takes the first written byte as a command that selects an access kind and a base register, and turns the byte sequence into reads and writes on a small external register file.

Byte, word and block accesses are served, including send-byte, receive-byte and process-call shapes, because the command is kept across a repeated start and across transactions. Writes are held in an internal buffer and committed to the register file only after STOP, one register per cycle, so a wrong length or a failed packet error check cancels them as a whole. With `pec_en` high the block checks the trailing CRC-8 byte of a write and appends one after the last data byte of a read.

Input stream rules: a byte moves when `in_valid` and `in_ready` are both high; `in_ack` is valid in that same cycle and tells the engine whether to ACK. `in_ready` is low only while a commit is running; the engine holds its byte until then. Output stream rules: a byte moves when `out_valid` and `out_ready` are both high; `out_data` is stable while `out_valid` is high and not yet taken. The register file read is combinational: `rd_data` must reflect `rd_addr` in the same cycle.

Top module: `smbus_target_resp`

## Requirements
- R1: The first byte after a start pulse is an address; it is ACKed only when bits [7:1] equal OWN_ADDR (bit 0 is the direction, 1 = read); for any other address that byte and every later byte up to the next start are NACKed and nothing is written.
- R2: The first byte written after the own address is the command: bits [7:6] = 00 selects a one-byte register, 10 a two-byte word, 01 a block, and 11 is unsupported and NACKed with no change to the stored command; bits [5:0] give the base register.
- R3: A read phase returns data starting at the base register of the stored command, whether it follows a repeated start in the same transaction or opens a new transaction with no command (receive byte).
- R4: Word values are written and read low byte first: the low byte lives at the base register and the high byte at base+1.
- R5: A block read sends a count byte first, equal to the register at base clamped to at most 32, then that many data bytes taken from base+1 upward.
- R6: In a block write the first byte after the command is a count stored at base and the data bytes follow at base+1 upward in arrival order; a count above 32 is NACKed, bytes beyond the declared count are NACKed, and any such write, or one with fewer bytes than declared, commits nothing.
- R7: Nothing reaches the register file before STOP; after a STOP that ends a valid write, the bytes are written one per cycle in ascending register order, and `in_ready` is low from the cycle after STOP until the last write.
- R8: After a host NACK on a transmitted byte, `out_valid` stays low until the next start.
- R9: With `pec_en` high, a read sends, right after its last data byte (1 for byte, 2 for word, count+1 for block), the CRC-8 (polynomial 0x07, initial value 0x00) over every byte of the transaction in order, including both address bytes; any byte requested after that, or after the data when `pec_en` is low, is 0xFF.
- R10: With `pec_en` high, a write-only transaction must end with a CRC-8 byte computed the same way over all preceding bytes; if it does not match, nothing is committed and `pec_err` goes high and stays high until reset.
- R11: A byte or word write that carries more data bytes than its kind allows has the extra bytes NACKed and commits nothing.
- R12: After reset `out_valid`, `wr_en` and `pec_err` are low, `in_ready` is high, and the stored command is 0x00 (one-byte register 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pec_en | input | 1 | Enables packet error checking on writes and generation on reads |
| bus_start | input | 1 | Pulse: start or repeated start seen on the bus |
| bus_stop | input | 1 | Pulse: stop seen on the bus |
| in_valid | input | 1 | Received byte available |
| in_ready | output | 1 | Responder can take a received byte |
| in_data | input | 8 | Received byte |
| in_ack | output | 1 | ACK decision for the byte in the handshake cycle |
| out_valid | output | 1 | Byte to transmit available |
| out_ready | input | 1 | Engine takes the byte to transmit |
| out_data | output | 8 | Byte to transmit |
| tx_nack | input | 1 | Pulse: host NACKed the last transmitted byte |
| rd_addr | output | RAW | Register file read address |
| rd_data | input | 8 | Register file read data, same cycle |
| wr_en | output | 1 | Register file write strobe |
| wr_addr | output | RAW | Register file write address |
| wr_data | output | 8 | Register file write data |
| pec_err | output | 1 | Sticky packet error check failure |

## Verification
A wrong command pointer or a misdecoded access kind shows on the very next transmitted byte, since every outgoing byte is a register value, a clamped count, a CRC or 0xFF at a fixed index. A buffer that counts bytes wrongly shows as an ACK where a NACK is due, within the byte that crosses the limit, or as missing or extra register writes in the few cycles after STOP. A corrupted CRC accumulator shows as a wrong trailing byte on a read and as a raised error flag or lost commit one cycle after STOP on a write.

// File: rtl/smbus_resp_pkg.sv
package smbus_resp_pkg;

  typedef enum logic [1:0] {
    K_BYTE  = 2'b00,
    K_BLOCK = 2'b01,
    K_WORD  = 2'b10,
    K_BAD   = 2'b11
  } cmd_kind_e;

  typedef enum logic [2:0] {
    PH_IGNORE,
    PH_ADDR,
    PH_CMD,
    PH_WDATA,
    PH_READ,
    PH_DONE
  } phase_e;

  // One byte through a CRC-8 with polynomial x^8+x^2+x+1, MSB first.
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[7] ^ d[i]) r = {r[6:0], 1'b0} ^ 8'h07;
      else             r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/smbus_pec_acc.sv
module smbus_pec_acc
  import smbus_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [7:0] crc
);

  logic [7:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= 8'h00;
    else if (clear) crc_q <= 8'h00;
    else if (upd)   crc_q <= crc8_step(crc_q, din);
  end

  assign crc = crc_q;

endmodule

// File: rtl/smbus_wbuf.sv
module smbus_wbuf #(
  parameter int DEPTH = 34,
  parameter int RAW   = 6,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           push,
  input  logic [7:0]     din,
  output logic [CW-1:0]  cnt,
  output logic [7:0]     head,
  input  logic           go,
  input  logic [RAW-1:0] base,
  input  logic [CW-1:0]  len,
  output logic           busy,
  output logic           wr_en,
  output logic [RAW-1:0] wr_addr,
  output logic [7:0]     wr_data
);

  logic [7:0]     mem_q [DEPTH];
  logic [CW-1:0]  cnt_q;
  logic           busy_q;
  logic [CW-1:0]  ci_q;
  logic [CW-1:0]  clen_q;
  logic [RAW-1:0] cbase_q;

  // Fill side: bytes land in arrival order.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (push) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem_q[cnt_q[IW-1:0]] <= din;
  end

  // Drain side: one register per cycle, ascending.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ci_q    <= '0;
      clen_q  <= '0;
      cbase_q <= '0;
    end else if (go && len != '0) begin
      busy_q  <= 1'b1;
      ci_q    <= '0;
      clen_q  <= len;
      cbase_q <= base;
    end else if (busy_q) begin
      ci_q <= ci_q + 1'b1;
      if (ci_q == clen_q - 1'b1) busy_q <= 1'b0;
    end
  end

  assign cnt     = cnt_q;
  assign head    = mem_q[0];
  assign busy    = busy_q;
  assign wr_en   = busy_q;
  assign wr_addr = cbase_q + RAW'(ci_q);
  assign wr_data = mem_q[ci_q[IW-1:0]];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |-> (cnt_q < CW'(DEPTH))); // R6
  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && len != '0) |-> !busy_q); // R7

endmodule

// File: rtl/smbus_target_resp.sv
module smbus_target_resp
  import smbus_resp_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR  = 7'h3A,
  parameter int         RAW       = 6,
  parameter int         MAX_BLOCK = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pec_en,
  input  logic           bus_start,
  input  logic           bus_stop,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [7:0]     in_data,
  output logic           in_ack,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [7:0]     out_data,
  input  logic           tx_nack,
  output logic [RAW-1:0] rd_addr,
  input  logic [7:0]     rd_data,
  output logic           wr_en,
  output logic [RAW-1:0] wr_addr,
  output logic [7:0]     wr_data,
  output logic           pec_err
);

  localparam int BUF_DEPTH = MAX_BLOCK + 2;
  localparam int CW        = $clog2(BUF_DEPTH + 1);
  localparam logic [7:0] MAXB8 = 8'(MAX_BLOCK);

  phase_e     phase_q;
  logic       active_q;
  logic [7:0] cmd_q;
  logic       cmd_seen_q;
  logic       rd_seen_q;
  logic       wbad_q;
  logic [7:0] k_q;
  logic [7:0] rlen_q;
  logic       pec_err_q;

  cmd_kind_e      kind;
  logic [RAW-1:0] base;
  logic [CW-1:0]  wcnt;
  logic [7:0]     whead;
  logic [7:0]     crc;
  logic           wbusy;
  logic           hs_in, hs_out, addr_hit;
  logic           accept_w;
  logic [7:0]     dlen8, wcnt8, pec8, need8;
  logic [7:0]     cnt_clamp;
  logic           need_chk, len_ok, pec_ok, commit_go;
  logic           buf_clr, buf_push, crc_clr, crc_upd;
  logic [7:0]     crc_din;

  assign kind     = cmd_kind_e'(cmd_q[7:6]);
  assign base     = cmd_q[RAW-1:0];
  assign in_ready = !wbusy;
  assign hs_in    = in_valid && in_ready && !bus_start && !bus_stop;
  assign addr_hit = (in_data[7:1] == OWN_ADDR);
  assign wcnt8    = 8'(wcnt);
  assign pec8     = {7'd0, pec_en};

  // Data length of the selected access kind (block: count plus data).
  always_comb begin
    case (kind)
      K_WORD:  dlen8 = 8'd2;
      K_BLOCK: dlen8 = 8'd1 + whead;
      default: dlen8 = 8'd1;
    endcase
  end

  // Acceptance of one more write byte at buffer index wcnt.
  always_comb begin
    if (wbad_q)                               accept_w = 1'b0;
    else if (kind == K_BLOCK && wcnt == '0)   accept_w = (in_data <= MAXB8);
    else                                      accept_w = (wcnt8 < dlen8 + pec8);
  end

  always_comb begin
    case (phase_q)
      PH_ADDR:  in_ack = addr_hit;
      PH_CMD:   in_ack = (in_data[7:6] != 2'b11);
      PH_WDATA: in_ack = accept_w;
      default:  in_ack = 1'b0;
    endcase
  end

  // Transmit path.
  assign cnt_clamp = (rd_data > MAXB8) ? MAXB8 : rd_data;
  assign rd_addr   = base + k_q[RAW-1:0];
  assign out_valid = (phase_q == PH_READ);
  assign hs_out    = out_valid && out_ready && !bus_start && !bus_stop;

  always_comb begin
    if (k_q < rlen_q)                  out_data = (kind == K_BLOCK && k_q == 8'd0) ? cnt_clamp : rd_data;
    else if (k_q == rlen_q && pec_en)  out_data = crc;
    else                               out_data = 8'hFF;
  end

  // Commit decision at STOP.
  assign need_chk  = pec_en && !rd_seen_q;
  assign need8     = {7'd0, need_chk};
  assign len_ok    = cmd_seen_q && !wbad_q && (wcnt != '0) && (wcnt8 == dlen8 + need8);
  assign pec_ok    = !need_chk || (crc == 8'h00);
  assign commit_go = bus_stop && len_ok && pec_ok;

  assign buf_clr  = hs_in && phase_q == PH_ADDR && addr_hit && !in_data[0];
  assign buf_push = hs_in && phase_q == PH_WDATA && accept_w;
  assign crc_clr  = bus_start && !active_q;
  assign crc_upd  = (hs_in && in_ack) || hs_out;
  assign crc_din  = hs_out ? out_data : in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IGNORE;
      active_q   <= 1'b0;
      cmd_q      <= 8'h00;
      cmd_seen_q <= 1'b0;
      rd_seen_q  <= 1'b0;
      wbad_q     <= 1'b0;
      k_q        <= 8'd0;
      rlen_q     <= 8'd1;
      pec_err_q  <= 1'b0;
    end else if (bus_stop) begin
      active_q <= 1'b0;
      phase_q  <= PH_IGNORE;
      if (need_chk && cmd_seen_q && wcnt != '0 && crc != 8'h00) pec_err_q <= 1'b1;
    end else if (bus_start) begin
      active_q <= 1'b1;
      phase_q  <= PH_ADDR;
      if (!active_q) begin
        cmd_seen_q <= 1'b0;
        rd_seen_q  <= 1'b0;
        wbad_q     <= 1'b0;
      end
    end else begin
      if (hs_in) begin
        case (phase_q)
          PH_ADDR: begin
            if (!addr_hit) phase_q <= PH_IGNORE;
            else if (in_data[0]) begin
              phase_q   <= PH_READ;
              rd_seen_q <= 1'b1;
              k_q       <= 8'd0;
              rlen_q    <= (kind == K_WORD) ? 8'd2 : 8'd1;
            end else begin
              phase_q    <= PH_CMD;
              cmd_seen_q <= 1'b0;
              wbad_q     <= 1'b0;
            end
          end
          PH_CMD: begin
            if (in_data[7:6] == 2'b11) phase_q <= PH_IGNORE;
            else begin
              cmd_q      <= in_data;
              cmd_seen_q <= 1'b1;
              phase_q    <= PH_WDATA;
            end
          end
          PH_WDATA: if (!accept_w) wbad_q <= 1'b1;
          default: ;
        endcase
      end
      if (hs_out) begin
        if (k_q != 8'hFF) k_q <= k_q + 8'd1;
        if (kind == K_BLOCK && k_q == 8'd0) rlen_q <= 8'd1 + cnt_clamp;
      end
      if (tx_nack && phase_q == PH_READ) phase_q <= PH_DONE;
    end
  end

  assign pec_err = pec_err_q;

  smbus_pec_acc u_pec (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (crc_clr),
    .upd   (crc_upd),
    .din   (crc_din),
    .crc   (crc)
  );

  smbus_wbuf #(.DEPTH(BUF_DEPTH), .RAW(RAW)) u_wbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (buf_clr),
    .push    (buf_push),
    .din     (in_data),
    .cnt     (wcnt),
    .head    (whead),
    .go      (commit_go),
    .base    (base),
    .len     (CW'(dlen8)),
    .busy    (wbusy),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(bus_stop)); // R7
  AST_NACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_nack && out_valid && !bus_start && !bus_stop) |=> !out_valid); // R8
  AST_PEC_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pec_err |=> pec_err); // R10
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_out && kind == K_BLOCK && k_q == 8'd0) |-> (out_data <= MAXB8)); // R5

endmodule

// File: tb/sim_smbus_target_resp.sv
`timescale 1ns/1ps
module sim_smbus_target_resp;

  localparam logic [7:0] AW = 8'h74;
  localparam logic [7:0] AR = 8'h75;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pec_en = 1'b0;
  logic       bus_start = 1'b0, bus_stop = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_ready = 1'b0, tx_nack = 1'b0;
  logic       in_ready, in_ack, out_valid, wr_en, pec_err;
  logic [7:0] out_data, rd_data, wr_data;
  logic [5:0] rd_addr, wr_addr;
  logic [7:0] regs [64];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) regs[i] <= 8'h00;
    end else if (wr_en) regs[wr_addr] <= wr_data;
  end
  assign rd_data = regs[rd_addr];

  smbus_target_resp u0 (
    .clk(clk), .rst_n(rst_n), .pec_en(pec_en), .bus_start(bus_start), .bus_stop(bus_stop),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_ack(in_ack),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .tx_nack(tx_nack),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pec_err(pec_err)
  );

  function automatic logic [7:0] crc_of(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) r = (r[7] ^ d[i]) ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) bus_start = 1'b1;
    @(negedge clk) bus_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) bus_stop = 1'b1;
    @(negedge clk) bus_stop = 1'b0;
    #1;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d, output logic ack);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    ack = in_ack;
    @(negedge clk) in_valid = 1'b0;
  endtask

  task automatic get(output logic [7:0] d, output logic vld);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    vld = out_valid; d = out_data;
    @(negedge clk) out_ready = 1'b0;
  endtask

  task automatic nack();
    @(negedge clk) tx_nack = 1'b1;
    @(negedge clk) tx_nack = 1'b0;
    #1;
  endtask

  // Write-only transaction: address, command, data bytes.
  task automatic wr_txn(input logic [7:0] cmd, input logic [7:0] d [], output logic [7:0] acks);
    logic a;
    acks = 8'h00;
    pulse_start();
    put(AW, a); put(cmd, a);
    foreach (d[i]) begin put(d[i], a); acks[i] = a; end
    pulse_stop();
    settle();
  endtask

  task automatic t_reset();
    #1;
    chk("R12 out_valid", {7'd0, out_valid}, 8'h00);
    chk("R12 wr_en", {7'd0, wr_en}, 8'h00);
    chk("R12 pec_err", {7'd0, pec_err}, 8'h00);
    chk("R12 in_ready", {7'd0, in_ready}, 8'h01);
    chk("R12 rd_addr cmd 0", {2'b0, rd_addr}, 8'h00);
  endtask

  task automatic t_byte();
    logic [7:0] acks, d; logic a, v;
    wr_txn(8'h05, '{8'hA5}, acks);
    chk("R2 byte data ack", {7'd0, acks[0]}, 8'h01);
    chk("R2 byte stored", regs[5], 8'hA5);
    pulse_start(); put(AW, a); put(8'h05, a);
    pulse_start(); put(AR, a);
    chk("R1 read addr ack", {7'd0, a}, 8'h01);
    get(d, v);
    chk("R3 read after repeated start", d, 8'hA5);
    get(d, v);
    chk("R9 padding without pec", d, 8'hFF);
    nack(); pulse_stop();
  endtask

  task automatic t_addr_miss();
    logic a; logic [7:0] d; logic v;
    pulse_start(); put(8'h44, a);
    chk("R1 foreign address nack", {7'd0, a}, 8'h00);
    put(8'h07, a);
    chk("R1 later byte nack", {7'd0, a}, 8'h00);
    put(8'h11, a);
    pulse_stop(); settle();
    chk("R1 no write", regs[7], 8'h00);
    pulse_start(); put(AR, a); get(d, v);
    chk("R1 command kept", d, 8'hA5);
    nack(); pulse_stop();
  endtask

  task automatic t_unsup();
    logic a; logic [7:0] d; logic v;
    pulse_start(); put(AW, a); put(8'hC3, a);
    chk("R2 unsupported nack", {7'd0, a}, 8'h00);
    pulse_stop(); settle();
    pulse_start(); put(AR, a); get(d, v);
    chk("R2 command unchanged", d, 8'hA5);
    nack(); pulse_stop();
  endtask

  task automatic t_word();
    logic [7:0] acks, d; logic a, v;
    wr_txn(8'h90, '{8'h34, 8'h12}, acks);
    chk("R4 low byte at base", regs[16], 8'h34);
    chk("R4 high byte at base+1", regs[17], 8'h12);
    pulse_start(); put(AR, a);
    get(d, v); chk("R3 receive byte low", d, 8'h34);
    get(d, v); chk("R4 read high second", d, 8'h12);
    nack(); pulse_stop();
  endtask

  task automatic t_extra();
    logic [7:0] acks;
    wr_txn(8'h07, '{8'h01, 8'h02}, acks);
    chk("R11 extra byte nack", {6'd0, acks[1:0]}, 8'h01);
    chk("R11 nothing committed", regs[7], 8'h00);
  endtask

  task automatic t_nack();
    logic a; logic [7:0] d; logic v;
    pulse_start(); put(AW, a); put(8'h05, a);
    pulse_start(); put(AR, a); get(d, v);
    nack();
    chk("R8 out_valid low after nack", {7'd0, out_valid}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R8 still low", {7'd0, out_valid}, 8'h00);
    pulse_stop();
  endtask

  task automatic t_block();
    logic a; logic [7:0] d; logic v;
    pulse_start(); put(AW, a); put(8'h60, a);
    put(8'h03, a); put(8'h11, a); put(8'h22, a); put(8'h33, a);
    chk("R6 last data ack", {7'd0, a}, 8'h01);
    chk("R7 no write before stop", regs[33], 8'h00);
    pulse_stop();
    chk("R7 in_ready low during commit", {7'd0, in_ready}, 8'h00);
    settle();
    chk("R7 in_ready back", {7'd0, in_ready}, 8'h01);
    chk("R6 count stored", regs[32], 8'h03);
    chk("R6 data order", {regs[33][3:0], regs[35][3:0]}, 8'h13);
    chk("R6 middle data", regs[34], 8'h22);
    pulse_start(); put(AW, a); put(8'h60, a);
    pulse_start(); put(AR, a);
    get(d, v); chk("R5 count first", d, 8'h03);
    get(d, v); chk("R5 data 0", d, 8'h11);
    get(d, v); get(d, v); chk("R5 data 2", d, 8'h33);
    get(d, v); chk("R9 block padding", d, 8'hFF);
    nack(); pulse_stop();
  endtask

  task automatic t_block_bad();
    logic a; logic [7:0] acks, d; logic v;
    pulse_start(); put(AW, a); put(8'h68, a); put(8'd40, a);
    chk("R6 count above 32 nack", {7'd0, a}, 8'h00);
    pulse_stop(); settle();
    chk("R6 no commit big count", regs[40], 8'h00);
    wr_txn(8'h68, '{8'h02, 8'hAA, 8'hBB, 8'hCC}, acks);
    chk("R6 beyond count nack", {4'd0, acks[3:0]}, 8'h07);
    chk("R6 no commit overrun", regs[41], 8'h00);
    wr_txn(8'h68, '{8'h02, 8'hAA}, acks);
    chk("R6 no commit short", regs[40], 8'h00);
    wr_txn(8'h30, '{8'd50}, acks);
    pulse_start(); put(AW, a); put(8'h70, a);
    pulse_start(); put(AR, a);
    get(d, v); chk("R5 count clamp", d, 8'd32);
    nack(); pulse_stop();
  endtask

  task automatic t_pec();
    logic a; logic [7:0] d, c, acks; logic v;
    pec_en = 1'b1;
    pulse_start(); put(AW, a); put(8'h05, a);
    pulse_start(); put(AR, a);
    get(d, v); chk("R9 data before pec", d, 8'hA5);
    c = crc_of(crc_of(crc_of(crc_of(8'h00, AW), 8'h05), AR), 8'hA5);
    get(d, v); chk("R9 pec byte", d, c);
    get(d, v); chk("R9 after pec", d, 8'hFF);
    nack(); pulse_stop(); settle();
    chk("R10 no error on read", {7'd0, pec_err}, 8'h00);
    c = crc_of(crc_of(crc_of(8'h00, AW), 8'h09), 8'h5A);
    wr_txn(8'h09, '{8'h5A, c}, acks);
    chk("R10 good pec commit", regs[9], 8'h5A);
    chk("R10 good pec no error", {7'd0, pec_err}, 8'h00);
    c = crc_of(crc_of(crc_of(8'h00, AW), 8'h0A), 8'h33) ^ 8'h01;
    wr_txn(8'h0A, '{8'h33, c}, acks);
    chk("R10 bad pec discarded", regs[10], 8'h00);
    chk("R10 bad pec flag", {7'd0, pec_err}, 8'h01);
    wr_txn(8'h0B, '{8'h44, crc_of(crc_of(crc_of(8'h00, AW), 8'h0B), 8'h44)}, acks);
    chk("R10 flag sticky", {7'd0, pec_err}, 8'h01);
    pec_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_byte();
    t_addr_miss();
    t_unsup();
    t_word();
    t_extra();
    t_nack();
    t_block();
    t_block_bad();
    t_pec();
    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < 100000 && !done; n++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule